// File: doc/BRIEF.md
# Message-Signalled Interrupt Aggregator

This block sits beside a PCIe root port and folds every inbound interrupt source into a single interrupt line toward the host CPU. Message-signalled interrupts arrive as address/data write pairs. Each of eight vector sets owns a programmable 64-bit capture address. A write that lands on that address latches one of 32 pending bits, and the data value picks the bit. Legacy INTA..INTD lines arrive as assert and deassert message pulses, and are kept as emulated level interrupts.

Pending state is summarised on two levels. Each set has a 32-bit status word and a 32-bit vector enable. A top-level status word holds one sticky summary bit per set and one bit per legacy line. A top-level enable word selects which of these drive the output, and a separate set-enable byte gates whole sets before they reach their summary bit. The host reads and writes all of this through a plain 32-bit register port with combinational read data. The interrupt handler drains a set's status by write-1-to-clear until the masked value is zero, and then clears the set's summary bit.

Top module: `msi_aggregator`

## Requirements
- R1: After reset every register reads zero and `irq_out` is low.
- R2: Set s has its capture address low word at 0xC00+0x10*s and its high word at 0xC80+4*s, its status at 0xC04+0x10*s and its vector enable at 0xC08+0x10*s. An inbound write whose 64-bit address equals {high,low} sets status bit (data mod 32) of that set in the next cycle.
- R3: Writing the status word of a set clears exactly the bits written as one. Every other status bit keeps its value.
- R4: If a capture and a write-1-to-clear hit the same status bit in the same cycle, the bit ends up set.
- R5: The top status register at 0x184 holds the summary bit for set s at bit 8+s. This bit is set one cycle after (status AND vector enable) of the set is nonzero while bit s of the set-enable register at 0x190 is one. Writing one clears the bit, but it sets again one cycle later while the set is still pending.
- R6: Legacy line i (0=INTA..3=INTD) sets bit 24+i of 0x184 on an assert pulse. Writing one to that bit has no effect while the line is still asserted. After a deassert pulse the bit stays set until it is written with one.
- R7: `irq_out` is one cycle after the OR of (top status AND top enable), where the top enable at 0x180 uses the same bit positions as 0x184.
- R8: An inbound write whose address matches no set changes no status bit.
- R9: Vectors whose enable bit is zero, and sets whose set-enable bit is zero, do not raise a summary bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr`, combinational |
| msi_valid | input | 1 | Inbound message write valid |
| msi_addr | input | 64 | Inbound message write address |
| msi_data | input | 32 | Inbound message write data (vector number) |
| intx_assert | input | 4 | Per-line assert message pulse, INTA at bit 0 |
| intx_deassert | input | 4 | Per-line deassert message pulse |
| irq_out | output | 1 | Combined registered interrupt to the host |

## Verification
Message writes are sent with data values above 31, so the modulo wrap is exercised. They are also sent to an address that differs from a programmed one only in its high word, which separates a full 64-bit match from a low-word-only match. A clear and a capture on the same vector in the same cycle distinguish capture priority from clear priority. The summary bit is cleared once while the set is still pending and once after draining, which shows that it re-arms. Legacy lines are cleared before and after their deassert message, which separates level emulation from a plain sticky bit. A behavioural model is compared against `irq_out` on every clock.

// File: rtl/msi_agg_pkg.sv
package msi_agg_pkg;
  localparam int REG_AW = 12;
  localparam int REG_DW = 32;
  localparam int MSG_AW = 64;

  localparam logic [REG_AW-1:0] OFS_TOP_EN   = 12'h180;
  localparam logic [REG_AW-1:0] OFS_TOP_STAT = 12'h184;
  localparam logic [REG_AW-1:0] OFS_SET_EN   = 12'h190;
  localparam int OFS_SET_BASE   = 'hC00;
  localparam int OFS_SET_STRIDE = 'h10;
  localparam int OFS_HI_BASE    = 'hC80;
  localparam int OFS_HI_STRIDE  = 4;

  localparam int SUM_LSB  = 8;
  localparam int INTX_LSB = 24;

  typedef enum logic [1:0] {
    FLD_ADDR_LO = 2'd0,
    FLD_STATUS  = 2'd1,
    FLD_ENABLE  = 2'd2
  } set_field_e;
endpackage

// File: rtl/msi_set_bank.sv
module msi_set_bank
  import msi_agg_pkg::*;
#(
  parameter int SET_IDX = 0,
  parameter int VEC_N   = 32,
  localparam int VW     = $clog2(VEC_N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [REG_DW-1:0] reg_wdata,
  output logic [REG_DW-1:0] rd_data,
  input  logic              in_valid,
  input  logic [MSG_AW-1:0] in_addr,
  input  logic [VW-1:0]     in_vec,
  output logic              pending
);
  localparam int BLK = OFS_SET_BASE + SET_IDX * OFS_SET_STRIDE;
  localparam logic [REG_AW-1:0] A_LO   = REG_AW'(BLK + 4 * int'(FLD_ADDR_LO));
  localparam logic [REG_AW-1:0] A_STAT = REG_AW'(BLK + 4 * int'(FLD_STATUS));
  localparam logic [REG_AW-1:0] A_EN   = REG_AW'(BLK + 4 * int'(FLD_ENABLE));
  localparam logic [REG_AW-1:0] A_HI   = REG_AW'(OFS_HI_BASE + SET_IDX * OFS_HI_STRIDE);

  logic [REG_DW-1:0] lo_q, hi_q;
  logic [VEC_N-1:0]  status_q, status_d, en_q;
  logic [VEC_N-1:0]  cap_mask, clr_mask;
  logic              lo_we, hi_we, en_we, clr_en, cap_hit, st_upd;

  // next-state
  always_comb begin
    lo_we    = reg_we && (reg_addr == A_LO);
    hi_we    = reg_we && (reg_addr == A_HI);
    en_we    = reg_we && (reg_addr == A_EN);
    clr_en   = reg_we && (reg_addr == A_STAT);
    cap_hit  = in_valid && (in_addr == {hi_q, lo_q});
    cap_mask = cap_hit ? (VEC_N'(1) << in_vec) : '0;
    clr_mask = clr_en ? reg_wdata[VEC_N-1:0] : '0;
    // capture is OR-ed in after the clear, so it wins a same-cycle collision
    status_d = (status_q & ~clr_mask) | cap_mask;
    st_upd   = cap_hit || clr_en;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q     <= '0;
      hi_q     <= '0;
      en_q     <= '0;
      status_q <= '0;
    end else begin
      if (lo_we)  lo_q     <= reg_wdata;
      if (hi_we)  hi_q     <= reg_wdata;
      if (en_we)  en_q     <= reg_wdata[VEC_N-1:0];
      if (st_upd) status_q <= status_d;
    end
  end

  assign pending = |(status_q & en_q);

  always_comb begin
    case (reg_addr)
      A_LO:    rd_data = lo_q;
      A_HI:    rd_data = hi_q;
      A_STAT:  rd_data = REG_DW'(status_q);
      A_EN:    rd_data = REG_DW'(en_q);
      default: rd_data = '0;
    endcase
  end

  // R2 / R4: a captured vector is pending in the following cycle
  assert_capture_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cap_hit |=> status_q[$past(in_vec)]);

  // R3: a clear without a capture leaves none of the written bits set
  assert_w1c_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !cap_hit) |=> ((status_q & $past(reg_wdata[VEC_N-1:0])) == '0));
endmodule

// File: rtl/intx_tracker.sv
module intx_tracker #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] asrt,
  input  logic [N-1:0] deasrt,
  input  logic [N-1:0] clr_mask,
  output logic [N-1:0] status
);
  logic [N-1:0] line_q, line_d, status_q, status_d;
  logic         upd;

  always_comb begin
    line_d   = asrt | (line_q & ~deasrt);
    // a clear takes effect only on lines already deasserted
    status_d = asrt | (status_q & ~(clr_mask & ~line_q));
    upd      = |{asrt, deasrt, clr_mask};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q   <= '0;
      status_q <= '0;
    end else if (upd) begin
      line_q   <= line_d;
      status_q <= status_d;
    end
  end

  assign status = status_q;

  // R6: while a line is held asserted its status bit cannot be cleared
  assert_level_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|line_q) |=> ((status_q & $past(line_q)) == $past(line_q)));
endmodule

// File: rtl/msi_aggregator.sv
module msi_aggregator
  import msi_agg_pkg::*;
#(
  parameter int NUM_SETS    = 8,
  parameter int VEC_PER_SET = 32,
  parameter int NUM_INTX    = 4,
  localparam int VW         = $clog2(VEC_PER_SET)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_we,
  input  logic [REG_AW-1:0]   reg_addr,
  input  logic [REG_DW-1:0]   reg_wdata,
  output logic [REG_DW-1:0]   reg_rdata,
  input  logic                msi_valid,
  input  logic [MSG_AW-1:0]   msi_addr,
  input  logic [REG_DW-1:0]   msi_data,
  input  logic [NUM_INTX-1:0] intx_assert,
  input  logic [NUM_INTX-1:0] intx_deassert,
  output logic                irq_out
);
  // reset: asserted asynchronously, released through two flops
  logic rs_meta, rs_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta <= 1'b0;
      rs_n    <= 1'b0;
    end else begin
      rs_meta <= 1'b1;
      rs_n    <= rs_meta;
    end
  end

  logic [VW-1:0]       msi_vec;
  logic [REG_DW-1:0]   bank_rd [NUM_SETS];
  logic [NUM_SETS-1:0] pend;

  assign msi_vec = VW'(msi_data % VEC_PER_SET);

  for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
    msi_set_bank #(.SET_IDX(s), .VEC_N(VEC_PER_SET)) u_bank (
      .clk      (clk),
      .rst_n    (rs_n),
      .reg_we   (reg_we),
      .reg_addr (reg_addr),
      .reg_wdata(reg_wdata),
      .rd_data  (bank_rd[s]),
      .in_valid (msi_valid),
      .in_addr  (msi_addr),
      .in_vec   (msi_vec),
      .pending  (pend[s])
    );
  end

  logic                top_stat_we, top_en_we, set_en_we;
  logic [NUM_SETS-1:0] set_en_q, sum_q, sum_d, sum_clr, sum_en_q;
  logic [NUM_INTX-1:0] intx_en_q, intx_clr, intx_stat;
  logic [REG_DW-1:0]   top_stat, top_en, banks_or;
  logic                irq_d;

  intx_tracker #(.N(NUM_INTX)) u_intx (
    .clk     (clk),
    .rst_n   (rs_n),
    .asrt    (intx_assert),
    .deasrt  (intx_deassert),
    .clr_mask(intx_clr),
    .status  (intx_stat)
  );

  // next-state
  always_comb begin
    top_stat_we = reg_we && (reg_addr == OFS_TOP_STAT);
    top_en_we   = reg_we && (reg_addr == OFS_TOP_EN);
    set_en_we   = reg_we && (reg_addr == OFS_SET_EN);
    sum_clr     = top_stat_we ? reg_wdata[SUM_LSB +: NUM_SETS] : '0;
    intx_clr    = top_stat_we ? reg_wdata[INTX_LSB +: NUM_INTX] : '0;
    // a still-pending set re-arms its summary over a clear
    sum_d       = (sum_q & ~sum_clr) | (set_en_q & pend);

    top_stat = '0;
    top_stat[SUM_LSB +: NUM_SETS]   = sum_q;
    top_stat[INTX_LSB +: NUM_INTX]  = intx_stat;
    top_en = '0;
    top_en[SUM_LSB +: NUM_SETS]     = sum_en_q;
    top_en[INTX_LSB +: NUM_INTX]    = intx_en_q;
    irq_d = |(top_stat & top_en);
  end

  // registers
  always_ff @(posedge clk or negedge rs_n) begin
    if (!rs_n) begin
      set_en_q  <= '0;
      sum_en_q  <= '0;
      intx_en_q <= '0;
      sum_q     <= '0;
      irq_out   <= 1'b0;
    end else begin
      if (set_en_we) set_en_q <= reg_wdata[NUM_SETS-1:0];
      if (top_en_we) begin
        sum_en_q  <= reg_wdata[SUM_LSB +: NUM_SETS];
        intx_en_q <= reg_wdata[INTX_LSB +: NUM_INTX];
      end
      sum_q   <= sum_d;
      irq_out <= irq_d;
    end
  end

  always_comb begin
    banks_or = '0;
    for (int s = 0; s < NUM_SETS; s++) banks_or = banks_or | bank_rd[s];
    case (reg_addr)
      OFS_TOP_EN:   reg_rdata = top_en;
      OFS_TOP_STAT: reg_rdata = top_stat;
      OFS_SET_EN:   reg_rdata = REG_DW'(set_en_q);
      default:      reg_rdata = banks_or;
    endcase
  end

  // R5: an enabled, pending set has its summary bit set in the next cycle
  assert_summary_arms_R5: assert property (@(posedge clk) disable iff (!rs_n)
    (|(set_en_q & pend)) |=> ((sum_q & $past(set_en_q & pend)) == $past(set_en_q & pend)));

  // R7: the output follows enabled top status with one cycle of delay
  assert_irq_rise_R7: assert property (@(posedge clk) disable iff (!rs_n)
    (|(top_stat & top_en)) |=> irq_out);
  assert_irq_quiet_R7: assert property (@(posedge clk) disable iff (!rs_n)
    !(|(top_stat & top_en)) |=> !irq_out);

  // R9: a set whose set-enable bit is low cannot newly raise its summary
  assert_gated_set_R9: assert property (@(posedge clk) disable iff (!rs_n)
    (top_stat_we && ((set_en_q & reg_wdata[SUM_LSB +: NUM_SETS]) == '0)
     && ((sum_q & ~reg_wdata[SUM_LSB +: NUM_SETS]) == '0))
    |=> ((sum_q & ~$past(set_en_q)) == '0));
endmodule

// File: tb/tb_msi_aggregator.sv
module tb_msi_aggregator;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [11:0] reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        msi_valid;
  logic [63:0] msi_addr;
  logic [31:0] msi_data;
  logic [3:0]  intx_assert, intx_deassert;
  logic        irq_out;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  msi_aggregator dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .msi_valid(msi_valid),
    .msi_addr(msi_addr), .msi_data(msi_data), .intx_assert(intx_assert),
    .intx_deassert(intx_deassert), .irq_out(irq_out)
  );

  // behavioural reference
  logic [31:0] m_lo [8], m_hi [8], m_st [8], m_en [8];
  logic [7:0]  m_seten, m_sum;
  logic [3:0]  m_line, m_istat;
  logic [31:0] m_topen;
  logic        m_irq;

  function automatic logic [31:0] mread(input logic [11:0] a);
    logic [31:0] r;
    r = 32'h0;
    if (a == 12'h180) r = m_topen;
    else if (a == 12'h184) r = {4'h0, m_istat, 8'h0, m_sum, 8'h0};
    else if (a == 12'h190) r = {24'h0, m_seten};
    else
      for (int s = 0; s < 8; s++) begin
        if (a == 12'(12'hC00 + 16*s)) r = m_lo[s];
        if (a == 12'(12'hC04 + 16*s)) r = m_st[s];
        if (a == 12'(12'hC08 + 16*s)) r = m_en[s];
        if (a == 12'(12'hC80 + 4*s))  r = m_hi[s];
      end
    return r;
  endfunction

  always @(posedge clk) begin : ref_model
    logic        irq_n;
    logic [7:0]  pend, sclr;
    logic [3:0]  iclr;
    logic [31:0] capm, clr;
    if (!rst_n) begin
      for (int s = 0; s < 8; s++) begin
        m_lo[s] = 0; m_hi[s] = 0; m_st[s] = 0; m_en[s] = 0;
      end
      m_seten = 0; m_sum = 0; m_line = 0; m_istat = 0; m_topen = 0; m_irq = 0;
    end else begin
      irq_n = |(mread(12'h184) & m_topen);
      sclr  = (reg_we && reg_addr == 12'h184) ? reg_wdata[15:8] : 8'h0;
      iclr  = (reg_we && reg_addr == 12'h184) ? reg_wdata[27:24] : 4'h0;
      for (int s = 0; s < 8; s++) begin
        pend[s] = |(m_st[s] & m_en[s]);
        capm = (msi_valid && msi_addr == {m_hi[s], m_lo[s]}) ? (32'h1 << (msi_data % 32)) : 32'h0;
        clr  = (reg_we && reg_addr == 12'(12'hC04 + 16*s)) ? reg_wdata : 32'h0;
        m_st[s] = (m_st[s] & ~clr) | capm;
        if (reg_we && reg_addr == 12'(12'hC00 + 16*s)) m_lo[s] = reg_wdata;
        if (reg_we && reg_addr == 12'(12'hC08 + 16*s)) m_en[s] = reg_wdata;
        if (reg_we && reg_addr == 12'(12'hC80 + 4*s))  m_hi[s] = reg_wdata;
      end
      m_sum   = (m_sum & ~sclr) | (m_seten & pend);
      m_istat = intx_assert | (m_istat & ~(iclr & ~m_line));
      m_line  = intx_assert | (m_line & ~intx_deassert);
      if (reg_we && reg_addr == 12'h190) m_seten = reg_wdata[7:0];
      if (reg_we && reg_addr == 12'h180) m_topen = reg_wdata & 32'h0F00_FF00;
      m_irq = irq_n;
    end
  end

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // R7: output compared with the model on every clock
  always @(negedge clk) if (rst_n && !done) chk({31'h0, irq_out}, {31'h0, m_irq}, "R7 irq_out");

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1 reg_we = 0;
  endtask

  task automatic msi(input logic [63:0] a, input logic [31:0] d);
    @(negedge clk); msi_valid = 1; msi_addr = a; msi_data = d;
    @(posedge clk); #1 msi_valid = 0;
  endtask

  task automatic msi_and_clr(input logic [63:0] a, input logic [31:0] d,
                             input logic [11:0] ra, input logic [31:0] rd);
    @(negedge clk); msi_valid = 1; msi_addr = a; msi_data = d;
    reg_we = 1; reg_addr = ra; reg_wdata = rd;
    @(posedge clk); #1 begin msi_valid = 0; reg_we = 0; end
  endtask

  task automatic intx(input logic [3:0] as, input logic [3:0] ds);
    @(negedge clk); intx_assert = as; intx_deassert = ds;
    @(posedge clk); #1 begin intx_assert = 0; intx_deassert = 0; end
  endtask

  task automatic rd(input logic [11:0] a, input string tag);
    @(negedge clk); reg_addr = a; #1;
    chk(reg_rdata, mread(a), tag);
  endtask

  task automatic rd_lit(input logic [11:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); reg_addr = a; #1;
    chk(reg_rdata, exp, tag);
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  localparam logic [63:0] A0 = 64'h0000_0000_FEE0_0000;
  localparam logic [63:0] A3 = 64'h0000_0001_FEE0_0030;

  initial begin
    rst_n = 0; reg_we = 0; reg_addr = 0; reg_wdata = 0;
    msi_valid = 0; msi_addr = 0; msi_data = 0; intx_assert = 0; intx_deassert = 0;
    idle(5);
    @(negedge clk) rst_n = 1;
    idle(4);

    // R1: reset values
    rd_lit(12'h180, 0, "R1 top enable");
    rd_lit(12'h184, 0, "R1 top status");
    rd_lit(12'h190, 0, "R1 set enable");
    rd_lit(12'hC04, 0, "R1 set0 status");
    rd_lit(12'hC28, 0, "R1 set2 enable");
    rd_lit(12'hC9C, 0, "R1 set7 high word");
    chk({31'h0, irq_out}, 0, "R1 irq low");

    // program capture addresses and enables
    wr(12'hC00, A0[31:0]);
    wr(12'hC80, A0[63:32]);
    wr(12'hC30, A3[31:0]);
    wr(12'hC8C, A3[63:32]);
    wr(12'h190, 32'hFF);
    wr(12'h180, 32'h0F00_FF00);
    rd_lit(12'hC30, 32'hFEE0_0030, "R2 set3 low word");
    rd_lit(12'hC8C, 32'h1, "R2 set3 high word");

    // R2: capture with modulo wrap; R9: enables still zero
    msi(A0, 5);
    msi(A0, 37);
    msi(A0, 31);
    rd_lit(12'hC04, 32'h8000_0020, "R2 set0 status");
    idle(2);
    rd_lit(12'h184, 0, "R9 masked vectors give no summary");

    // R5: enabling vector 5 raises summary and irq
    wr(12'hC08, 32'h0000_0020);
    idle(2);
    rd_lit(12'h184, 32'h0000_0100, "R5 set0 summary set");

    // R8: high word differs from set3, low word matches
    msi({32'h2, A3[31:0]}, 9);
    msi(64'h0000_0000_DEAD_0000, 3);
    rd_lit(12'hC34, 0, "R8 set3 untouched");
    rd_lit(12'hC04, 32'h8000_0020, "R8 set0 untouched");
    msi(A3, 64 + 9);
    rd_lit(12'hC34, 32'h0000_0200, "R2 set3 capture");

    // R3: clear only bit 5
    wr(12'hC04, 32'h0000_0020);
    rd_lit(12'hC04, 32'h8000_0000, "R3 selective clear");

    // R4: capture and clear of bit 7 in the same cycle
    msi_and_clr(A0, 7, 12'hC04, 32'h0000_0080);
    rd_lit(12'hC04, 32'h8000_0080, "R4 capture wins");

    // R5: summary re-arms while still pending, stays clear after drain
    wr(12'hC08, 32'h0000_0080);
    idle(2);
    wr(12'h184, 32'h0000_0100);
    idle(1);
    rd(12'h184, "R5 re-arm while pending");
    wr(12'hC04, 32'hFFFF_FFFF);
    idle(1);
    wr(12'h184, 32'h0000_0100);
    idle(2);
    rd_lit(12'h184, 0, "R5 cleared after drain");

    // R9: set3 gated off by set-enable
    wr(12'h190, 32'hF7);
    wr(12'hC38, 32'h0000_0200);
    idle(3);
    rd_lit(12'h184, 0, "R9 gated set");
    wr(12'h190, 32'hFF);
    idle(2);
    rd_lit(12'h184, 32'h0000_0800, "R5 set3 summary after ungate");
    wr(12'hC34, 32'h0000_0200);
    idle(1);
    wr(12'h184, 32'h0000_0800);
    idle(2);

    // R6: INTB level emulation
    intx(4'b0010, 4'b0000);
    rd_lit(12'h184, 32'h0200_0000, "R6 INTB set");
    wr(12'h184, 32'h0200_0000);
    rd_lit(12'h184, 32'h0200_0000, "R6 clear ignored while asserted");
    intx(4'b0000, 4'b0010);
    rd_lit(12'h184, 32'h0200_0000, "R6 persists after deassert");
    wr(12'h184, 32'h0200_0000);
    rd_lit(12'h184, 0, "R6 clear after deassert");

    // R7: top enable masks output
    wr(12'h180, 32'h0000_0000);
    intx(4'b1000, 4'b0000);
    idle(3);
    chk({31'h0, irq_out}, 0, "R7 masked by top enable");
    wr(12'h180, 32'h0800_0000);
    idle(2);
    chk({31'h0, irq_out}, 1, "R7 raised by top enable");
    rd(12'h180, "R7 top enable readback");

    idle(3);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule